// File: doc/BRIEF.md
# Two-Row Key Matrix Scanner

This block reads a key matrix of sixteen source lines and two return lines. The source lines are the segment outputs of a multiplexed display. A display timing generator marks the start of each frame and the start of the spare key slot that follows the last digit. Inside that slot the scanner drives one source line at a time. Each source gets an equal share of the slot. Both return lines are sampled near the end of each share.

A full pass over the matrix needs two key slots. The first slot after start-up covers sources 1 to 8 and the next covers sources 9 to 16, and the two halves keep alternating. The sixteen samples of a half are collected in a shadow register and written to the key memory in one step when the half completes. A byte read by the serial interface therefore never mixes old and new samples. The memory is presented as four bytes. Each source owns two adjacent bits, the lower one for the first return line. Scanning is held off whenever the enable flag is low, which covers power-up and display-mode changes.

Top module: `kmx_scanner`

## Requirements
- R1: After reset, every source line is low, all 32 key bits are 0, and the next slot scans the first half (sources 1 to 8).
- R2: At most one source line is high in any cycle. No source line is high outside an active key slot.
- R3: A slot strobe sampled at edge t starts a slot. Source k of the current half (k = 0..7, in ascending order) is driven after edge t+k·SUB_CYC until edge t+(k+1)·SUB_CYC. Every source line is low after edge t+8·SUB_CYC.
- R4: Completed slots alternate between the first half (sources 1 to 8) and the second half (sources 9 to 16).
- R5: Key bit index 2·s+r holds source s (s = 0..15, source 1 is s = 0) for return r (r = 0 is the first return line, r = 1 the second). Byte b (bits 8b+7..8b) therefore holds sources 4b+1 to 4b+4.
- R6: A key bit is 1 exactly when its return line, after SYNC_STAGES register stages, was high at the last edge of its source's sub-interval.
- R7: The 16 bits of a half change only at the edge that ends that half's slot (edge t+8·SUB_CYC), all together. The other half keeps its value.
- R8: While the enable input is low, all source lines are low, slot strobes are ignored, the key memory holds its value, and the first slot after re-enabling scans the first half.
- R9: A frame strobe during an active slot ends it. All source lines are low from the next cycle, the key memory does not change, and the next slot scans the same half again. A frame strobe takes priority over a slot strobe in the same cycle.
- R10: A slot strobe that arrives while a slot is active is ignored. The running slot keeps its source order and ends at its original time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_en | input | 1 | Scanning allowed; low stops and restarts the scan |
| frame_stb | input | 1 | One-cycle pulse at the start of a display frame |
| slot_stb | input | 1 | One-cycle pulse at the start of the key slot |
| key_ret | input | NRET (2) | Return lines from the matrix, bit 0 is the first row |
| src_drive | output | NSRC (16) | Key source drive, bit s is source s+1 |
| key_bytes | output | NSRC·NRET (32) | Key memory, byte b in bits 8b+7..8b |

## Verification
If the sub-interval or source counter is off by one, src_drive shows it within a single sub-interval of the slot strobe: the one-hot bit moves at the wrong edge or skips a source. If the half-select state is wrong, the wrong 16 bits of key_bytes change when the slot ends, 8·SUB_CYC cycles after the strobe. If the shadow shift direction or the packing is wrong, bits land at the wrong positions in that same update. If an abort or disable is mishandled, key_bytes changes with no completed slot, or the first source of the following slot is one from the wrong half.

// File: rtl/kmx_pkg.sv
package kmx_pkg;

   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_SCAN = 1'b1
   } seq_state_e;

   // counter width that never collapses to zero bits
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/kmx_sync.sv
module kmx_sync #(
   parameter int unsigned W      = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
            end else begin
               stg_q[0] <= d;
               for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
            end
         end
         assign q = stg_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/kmx_seq.sv
module kmx_seq
   import kmx_pkg::*;
#(
   parameter int unsigned HALF_SRC = 8,
   parameter int unsigned SUB_CYC  = 4,
   localparam int unsigned IDXW    = cnt_width(HALF_SRC),
   localparam int unsigned SUBW    = cnt_width(SUB_CYC)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            scan_en,
   input  logic            frame_stb,
   input  logic            slot_stb,
   output logic            active,
   output logic [IDXW-1:0] src_idx,
   output logic            half,
   output logic            sample,
   output logic            commit
);
   seq_state_e      st_q;
   logic [IDXW-1:0] idx_q;
   logic [SUBW-1:0] sub_q;
   logic            half_q;
   logic            last_sub, last_src, go;

   assign last_sub = (sub_q == SUBW'(SUB_CYC - 1));
   assign last_src = (idx_q == IDXW'(HALF_SRC - 1));
   assign go       = scan_en && !frame_stb;

   assign active  = (st_q == SEQ_SCAN);
   assign src_idx = idx_q;
   assign half    = half_q;
   assign sample  = go && active && last_sub;
   assign commit  = sample && last_src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SEQ_IDLE;
         idx_q  <= '0;
         sub_q  <= '0;
         half_q <= 1'b0;
      end else if (!scan_en) begin
         st_q   <= SEQ_IDLE;
         idx_q  <= '0;
         sub_q  <= '0;
         half_q <= 1'b0;
      end else if (frame_stb) begin
         st_q  <= SEQ_IDLE;
         idx_q <= '0;
         sub_q <= '0;
      end else if (st_q == SEQ_IDLE) begin
         if (slot_stb) begin
            st_q  <= SEQ_SCAN;
            idx_q <= '0;
            sub_q <= '0;
         end
      end else if (last_sub) begin
         sub_q <= '0;
         if (last_src) begin
            st_q   <= SEQ_IDLE;
            idx_q  <= '0;
            half_q <= ~half_q;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end else begin
         sub_q <= sub_q + 1'b1;
      end
   end
endmodule

// File: rtl/kmx_store.sv
module kmx_store #(
   parameter int unsigned HALF_SRC = 8,
   parameter int unsigned NRET     = 2,
   localparam int unsigned HALF_BITS = HALF_SRC * NRET,
   localparam int unsigned KEY_BITS  = 2 * HALF_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sample,
   input  logic                commit,
   input  logic                half,
   input  logic [NRET-1:0]     ret_s,
   output logic [KEY_BITS-1:0] key_mem
);
   logic [HALF_BITS-1:0] shadow_q;
   logic [HALF_BITS-1:0] shadow_nxt;

   // newest pair enters at the top; after a full half the first source sits at the bottom
   generate
      if (HALF_SRC == 1) begin : g_one
         assign shadow_nxt = ret_s;
      end else begin : g_many
         assign shadow_nxt = {ret_s, shadow_q[HALF_BITS-1:NRET]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      shadow_q <= '0;
      else if (sample) shadow_q <= shadow_nxt;
   end

   generate
      for (genvar h = 0; h < 2; h++) begin : g_half
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               key_mem[h*HALF_BITS +: HALF_BITS] <= '0;
            else if (commit && (half == 1'(h)))
               key_mem[h*HALF_BITS +: HALF_BITS] <= shadow_nxt;
         end
      end
   endgenerate
endmodule

// File: rtl/kmx_scanner.sv
module kmx_scanner #(
   parameter int unsigned NSRC        = 16,
   parameter int unsigned NRET        = 2,
   parameter int unsigned SUB_CYC     = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   scan_en,
   input  logic                   frame_stb,
   input  logic                   slot_stb,
   input  logic [NRET-1:0]        key_ret,
   output logic [NSRC-1:0]        src_drive,
   output logic [NSRC*NRET-1:0]   key_bytes
);
   localparam int unsigned HALF_SRC  = NSRC / 2;
   localparam int unsigned HALF_BITS = HALF_SRC * NRET;
   localparam int unsigned KEY_BITS  = NSRC * NRET;
   localparam int unsigned IDXW      = kmx_pkg::cnt_width(HALF_SRC);

   generate
      if (NSRC < 2 || (NSRC % 2) != 0) begin : g_bad_nsrc
         $error("NSRC must be even and at least 2");
      end
      if (NRET < 1) begin : g_bad_nret
         $error("NRET must be at least 1");
      end
      if ((HALF_BITS % 8) != 0) begin : g_bad_bytes
         $error("each half must fill whole bytes");
      end
      if (SUB_CYC <= SYNC_STAGES) begin : g_bad_sub
         $error("SUB_CYC must exceed SYNC_STAGES so the sample sees its own source");
      end
   endgenerate

   logic [NRET-1:0] ret_s;
   logic            active_w, half_w, sample_w, commit_w;
   logic [IDXW-1:0] idx_w;

   kmx_sync #(.W(NRET), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (key_ret),
      .q     (ret_s)
   );

   kmx_seq #(.HALF_SRC(HALF_SRC), .SUB_CYC(SUB_CYC)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .scan_en   (scan_en),
      .frame_stb (frame_stb),
      .slot_stb  (slot_stb),
      .active    (active_w),
      .src_idx   (idx_w),
      .half      (half_w),
      .sample    (sample_w),
      .commit    (commit_w)
   );

   kmx_store #(.HALF_SRC(HALF_SRC), .NRET(NRET)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .sample  (sample_w),
      .commit  (commit_w),
      .half    (half_w),
      .ret_s   (ret_s),
      .key_mem (key_bytes)
   );

   generate
      for (genvar h = 0; h < 2; h++) begin : g_drv_half
         for (genvar j = 0; j < int'(HALF_SRC); j++) begin : g_drv_src
            assign src_drive[h*HALF_SRC + j] =
               active_w && (half_w == 1'(h)) && (idx_w == IDXW'(j));
         end
      end
   endgenerate
endmodule

// File: rtl/kmx_chk.sv
module kmx_chk #(
   parameter int unsigned NSRC     = 16,
   parameter int unsigned KEY_BITS = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                scan_en,
   input logic                frame_stb,
   input logic                commit,
   input logic [NSRC-1:0]     src_drive,
   input logic [KEY_BITS-1:0] key_bytes
);
   localparam int unsigned HB = KEY_BITS / 2;

   // R2
   src_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(src_drive));

   // R8
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_en |=> (src_drive == '0));

   // R9
   abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stb |=> (src_drive == '0));

   // R7
   mem_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(key_bytes) |-> $past(commit));

   // R7
   half_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(key_bytes[HB-1:0]) || $stable(key_bytes[KEY_BITS-1:HB]));
endmodule

bind kmx_scanner kmx_chk #(.NSRC(NSRC), .KEY_BITS(KEY_BITS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scan_en   (scan_en),
   .frame_stb (frame_stb),
   .commit    (commit_w),
   .src_drive (src_drive),
   .key_bytes (key_bytes)
);

// File: tb/kmx_scanner_bench.sv
module kmx_scanner_bench;
   localparam int NSRC = 16;
   localparam int HALF = 8;
   localparam int S    = 4;

   logic        clk = 1'b0;
   logic        rst_n, scan_en, frame_stb, slot_stb;
   logic [1:0]  key_ret;
   logic [15:0] src_drive;
   logic [31:0] key_bytes;
   logic [15:0] row1, row2;   // pressed keys per return line

   int          n_tests = 0, n_fail = 0;
   logic [31:0] exp_mem;
   int          exp_half;

   always #5 clk = ~clk;

   assign key_ret[0] = |(src_drive & row1);
   assign key_ret[1] = |(src_drive & row2);

   kmx_scanner u_kmx_scanner (
      .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .frame_stb(frame_stb),
      .slot_stb(slot_stb), .key_ret(key_ret), .src_drive(src_drive),
      .key_bytes(key_bytes)
   );

   // R5 packing: bit 2*s+r within the whole memory
   function automatic logic [31:0] mem_after(input logic [31:0] old, input int h);
      logic [31:0] m = old;
      for (int j = 0; j < HALF; j++) begin
         m[2*(h*HALF+j)]   = row1[h*HALF+j];
         m[2*(h*HALF+j)+1] = row2[h*HALF+j];
      end
      return m;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // abort_at / dis_at / restb_at: sub-cycle index m at which to inject, -1 none
   task automatic run_slot(input int abort_at, input int dis_at, input int restb_at);
      bit          drv_ok = 1'b1;
      logic [15:0] bad_a = '0, bad_e = '0;
      @(negedge clk); slot_stb = 1'b1;
      @(negedge clk); slot_stb = 1'b0;
      for (int m = 0; m < HALF*S; m++) begin
         logic [15:0] e = 16'(1) << (exp_half*HALF + m/S);
         slot_stb = 1'b0;
         if (src_drive !== e && drv_ok) begin drv_ok = 1'b0; bad_a = src_drive; bad_e = e; end
         if (m == abort_at) begin
            check(drv_ok, "R3", "drive before abort", 32'(bad_a), 32'(bad_e));
            frame_stb = 1'b1;
            @(negedge clk); frame_stb = 1'b0;
            check(src_drive == '0, "R9", "drive after abort", 32'(src_drive), 0);
            repeat (HALF*S) @(negedge clk);
            check(key_bytes == exp_mem, "R9", "memory after abort", key_bytes, exp_mem);
            return;
         end
         if (m == dis_at) begin
            scan_en = 1'b0;
            @(negedge clk);
            check(src_drive == '0, "R8", "drive when disabled", 32'(src_drive), 0);
            slot_stb = 1'b1;
            @(negedge clk); slot_stb = 1'b0;
            repeat (3) @(negedge clk);
            check(src_drive == '0, "R8", "strobe while disabled", 32'(src_drive), 0);
            repeat (HALF*S) @(negedge clk);
            check(key_bytes == exp_mem, "R8", "memory held", key_bytes, exp_mem);
            scan_en = 1'b1;
            exp_half = 0;
            return;
         end
         if (m == restb_at) slot_stb = 1'b1;   // R10 stray strobe
         @(negedge clk);
      end
      slot_stb = 1'b0;
      check(drv_ok, (restb_at >= 0) ? "R10" : "R3", "source order", 32'(bad_a), 32'(bad_e));
      check(src_drive == '0, "R2", "drive after slot", 32'(src_drive), 0);
      exp_mem = mem_after(exp_mem, exp_half);
      check(key_bytes == exp_mem, "R6", "key memory", key_bytes, exp_mem);
      exp_half ^= 1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; scan_en = 1'b0; frame_stb = 1'b0; slot_stb = 1'b0;
      row1 = '0; row2 = '0; exp_mem = '0; exp_half = 0;
      repeat (4) @(negedge clk);
      check(src_drive == '0, "R1", "reset drive", 32'(src_drive), 0);
      check(key_bytes == '0, "R1", "reset memory", key_bytes, 0);
      rst_n = 1'b1; scan_en = 1'b1;
      @(negedge clk);

      // R1 R4: first slot scans first half, then second
      row1 = $urandom(); row2 = $urandom();
      run_slot(-1, -1, -1);
      check(key_bytes[31:16] == '0, "R4", "second half untouched", 32'(key_bytes[31:16]), 0);
      run_slot(-1, -1, -1);

      // R5: corner keys, source 1 first row -> bit0, source 16 second row -> bit31
      row1 = 16'h0001; row2 = 16'h8000;
      run_slot(-1, -1, -1); run_slot(-1, -1, -1);
      check(key_bytes == 32'h8000_0001, "R5", "corner keys", key_bytes, 32'h8000_0001);
      row1 = 16'h0010; row2 = 16'h0000;    // source 5 row 1 -> byte 1 bit 0
      run_slot(-1, -1, -1); run_slot(-1, -1, -1);
      check(key_bytes == 32'h0000_0100, "R5", "byte boundary", key_bytes, 32'h0000_0100);
      row1 = '1; row2 = '1;
      run_slot(-1, -1, -1); run_slot(-1, -1, -1);

      // R9: abort mid-slot, then same half rescanned
      row1 = 16'h5A5A; row2 = 16'hA5A5;
      run_slot(13, -1, -1);
      run_slot(-1, -1, -1);
      run_slot(-1, -1, -1);

      // R10: stray strobe during slot
      row1 = $urandom(); row2 = $urandom();
      run_slot(-1, -1, 9);
      run_slot(-1, -1, 20);

      // R8: disable during second half, restart from first half
      run_slot(-1, -1, -1);
      check(exp_half == 1, "R4", "phase before disable", 32'(exp_half), 1);
      run_slot(-1, 5, -1);
      row1 = $urandom(); row2 = $urandom();
      run_slot(-1, -1, -1);
      run_slot(-1, -1, -1);

      // random mix
      for (int i = 0; i < 24; i++) begin
         int r = $urandom_range(0, 9);
         row1 = $urandom(); row2 = $urandom();
         if (r == 0)      run_slot($urandom_range(0, HALF*S-1), -1, -1);
         else if (r == 1) run_slot(-1, $urandom_range(0, HALF*S-1), -1);
         else if (r == 2) run_slot(-1, -1, $urandom_range(0, HALF*S-1));
         else             run_slot(-1, -1, -1);
         repeat ($urandom_range(0, 5)) @(negedge clk);
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule